// File: doc/BRIEF.md
# Serial ADC command byte decoder

This block sits on the converter side of a four-wire serial command port. It watches an active-low chip select, a serial clock and a serial data line, all asynchronous to the system clock. It skips the zeros that lead the first 1 and then frames each 8-bit command byte, most significant bit first. Each finished byte is classified by its low nibble. A mode-control byte updates the conversion-mode register. Any other byte is an input-configuration byte and updates the channel, differential flag and range registers.

After an input-configuration byte, the block counts serial-clock falling edges. It raises a one-cycle sample pulse on the edge that the current conversion mode sets for the sampling instant. In mode 1 it also drives a conversion strobe high from the sample until chip select is released. The three pins pass through two-flop synchronizers. Data is taken on serial-clock rising edges and counting is done on falling edges, both seen in the system-clock domain. The serial clock must therefore stay in each level for several system clocks.

Top module: `adc_cmd_decoder`

## Requirements
- R1: After reset, chanSel, diffSel, rangeCode and convMode are all 0, and cfgStrobe, modeStrobe, samplePulse and strobeOut are low.
- R2: While chip select is low, DIN zeros sampled before the first 1 are ignored. The first 1 is the start bit and is bit 7 of the byte, and the next seven serial-clock rising edges supply bits 6 down to 0.
- R3: A byte whose bits 3..0 are 1000 is a mode-control byte. Bits 6..4 load convMode, modeStrobe pulses high for one cycle, and the channel, differential and range registers keep their values.
- R4: Any other byte is an input-configuration byte. Bits 6..4 load chanSel, bit 3 loads diffSel, bits 2..0 load rangeCode, cfgStrobe pulses for one cycle, and convMode is unchanged.
- R5: With convMode 0, an input-configuration byte leads to exactly one samplePulse, after the falling edge of the 14th serial clock. The clock that carries the start bit counts as the 1st.
- R6: With convMode 1, the sample pulse follows the falling edge of the 16th serial clock, counted the same way.
- R7: With convMode 2 to 7, no sample pulse is produced.
- R8: strobeOut is low whenever convMode is 0. In mode 1 it rises with the sample pulse and falls when chip select goes high or a mode-control byte is taken.
- R9: Chip select going high discards a partial byte without changing any register or strobe. It also cancels a pending sample, and the next frame counts clocks from its own start bit.
- R10: After an input-configuration byte and before its sample pulse, DIN is ignored: no new byte is framed in that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Chip select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| din | input | 1 | Serial command data, asynchronous |
| chanSel | output | 3 | Selected input channel |
| diffSel | output | 1 | 1 = differential, 0 = single-ended |
| rangeCode | output | 3 | Input range code |
| convMode | output | 3 | Conversion mode |
| cfgStrobe | output | 1 | One-cycle pulse when a configuration byte is taken |
| modeStrobe | output | 1 | One-cycle pulse when a mode-control byte is taken |
| samplePulse | output | 1 | One-cycle pulse at the sampling instant |
| strobeOut | output | 1 | Conversion strobe, held low in mode 0 |

## Verification
The hardest states to reach are an abort that lands mid-count, inside the conversion window, and DIN activity inside that window that could look like a new start bit. The bench drives a configuration byte with only 12 clocks and then releases chip select. It then checks that no pulse appears, and that a fresh frame samples at its own 14th edge. A separate frame holds DIN at 1 through all the trailing clocks, to show that the ones before the sample are not framed as a byte. Strobe clearing on a mode byte is reached by sending a mode-1 conversion and a mode-control byte under one chip-select window.

// File: rtl/adc_cmd_pkg.sv
package adc_cmd_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic shiftEn;
    logic clearShift;
    logic byteDone;
  } ctlStrobes_t;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_CONV  = 2'd2
  } ctrlState_e;
endpackage

// File: rtl/adc_pin_sync.sv
module adc_pin_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pinsIn,
  output logic [WIDTH-1:0] pinsSync
);
  generate
    if (STAGES == 1) begin : g_single
      logic [WIDTH-1:0] stageQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ <= RESET_VAL;
        else       stageQ <= pinsIn;
      end
      assign pinsSync = stageQ;
    end else begin : g_chain
      logic [STAGES*WIDTH-1:0] chainQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chainQ <= {STAGES{RESET_VAL}};
        else       chainQ <= {chainQ[(STAGES-1)*WIDTH-1:0], pinsIn};
      end
      assign pinsSync = chainQ[STAGES*WIDTH-1 -: WIDTH];
    end
  endgenerate
endmodule

// File: rtl/adc_cmd_ctrl.sv
module adc_cmd_ctrl
  import adc_cmd_pkg::*;
#(
  parameter int BYTE_BITS    = 8,
  parameter int MODE_W       = 3,
  parameter int MODE0_SAMPLE = 14,
  parameter int MODE1_SAMPLE = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csActive,
  input  logic              sclkLvl,
  input  logic              dinBit,
  input  logic              isModeByte,
  input  logic [MODE_W-1:0] convMode,
  output ctlStrobes_t       ctl,
  output logic              samplePulse,
  output logic              strobeOut
);
  localparam int BIT_W = $clog2(BYTE_BITS);
  localparam int MAX_SAMPLE = (MODE0_SAMPLE > MODE1_SAMPLE) ? MODE0_SAMPLE : MODE1_SAMPLE;
  localparam int CNT_W = $clog2(MAX_SAMPLE + 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_BITS - 1);
  localparam logic [CNT_W-1:0] TARGET0 = CNT_W'(MODE0_SAMPLE);
  localparam logic [CNT_W-1:0] TARGET1 = CNT_W'(MODE1_SAMPLE);

  ctrlState_e       state;
  logic [BIT_W-1:0] bitCnt;
  logic [CNT_W-1:0] fallCnt;
  logic             sclkPrev;
  logic             sclkRise, sclkFall;
  logic             modeSamples;
  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] fallNext;

  assign sclkRise    = sclkLvl & ~sclkPrev;
  assign sclkFall    = ~sclkLvl & sclkPrev;
  assign modeSamples = (convMode <= MODE_W'(1));
  assign target      = (convMode == '0) ? TARGET0 : TARGET1;
  assign fallNext    = fallCnt + 1'b1;

  always_comb begin
    ctl = '0;
    if (!csActive) begin
      ctl.clearShift = 1'b1;
    end else begin
      unique case (state)
        ST_HUNT:  ctl.shiftEn = sclkRise & dinBit;
        ST_SHIFT: begin
          ctl.byteDone = sclkRise & (bitCnt == LAST_BIT);
          ctl.shiftEn  = sclkRise & (bitCnt != LAST_BIT);
        end
        default:  ctl = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkPrev <= 1'b0;
    else       sclkPrev <= sclkLvl;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_HUNT;
      bitCnt      <= '0;
      fallCnt     <= '0;
      samplePulse <= 1'b0;
      strobeOut   <= 1'b0;
    end else if (!csActive) begin
      state       <= ST_HUNT;
      bitCnt      <= '0;
      fallCnt     <= '0;
      samplePulse <= 1'b0;
      strobeOut   <= 1'b0;
    end else begin
      samplePulse <= 1'b0;
      unique case (state)
        ST_HUNT: begin
          if (sclkRise && dinBit) begin
            state   <= ST_SHIFT;
            bitCnt  <= BIT_W'(1);
            fallCnt <= '0;
          end
        end
        ST_SHIFT: begin
          if (sclkFall) fallCnt <= fallNext;
          if (sclkRise) begin
            if (bitCnt == LAST_BIT) begin
              bitCnt <= '0;
              state  <= (!isModeByte && modeSamples) ? ST_CONV : ST_HUNT;
              if (isModeByte) strobeOut <= 1'b0;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
        ST_CONV: begin
          if (sclkFall) begin
            fallCnt <= fallNext;
            if (fallNext == target) begin
              samplePulse <= 1'b1;
              state       <= ST_HUNT;
              if (convMode != '0) strobeOut <= 1'b1;
            end
          end
        end
        default: state <= ST_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/adc_cmd_datapath.sv
module adc_cmd_datapath
  import adc_cmd_pkg::*;
#(
  parameter int CHAN_W  = 3,
  parameter int RANGE_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        ctl,
  input  logic               dinBit,
  output logic               isModeByte,
  output logic [CHAN_W-1:0]  chanSel,
  output logic               diffSel,
  output logic [RANGE_W-1:0] rangeCode,
  output logic [CHAN_W-1:0]  convMode,
  output logic               cfgStrobe,
  output logic               modeStrobe
);
  localparam int PAYLOAD_W = CHAN_W + 1 + RANGE_W;
  localparam int SHIFT_W   = PAYLOAD_W - 1;
  localparam int TAG_W     = RANGE_W + 1;
  localparam int DIFF_POS  = RANGE_W;
  localparam int CHAN_LSB  = RANGE_W + 1;
  localparam logic [TAG_W-1:0] MODE_TAG = {1'b1, {RANGE_W{1'b0}}};

  logic [SHIFT_W-1:0]   shiftReg;
  logic [PAYLOAD_W-1:0] payload;

  // Start bit enters first and falls off the top after the seventh shift
  assign payload    = {shiftReg, dinBit};
  assign isModeByte = (payload[TAG_W-1:0] == MODE_TAG);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg   <= '0;
      chanSel    <= '0;
      diffSel    <= 1'b0;
      rangeCode  <= '0;
      convMode   <= '0;
      cfgStrobe  <= 1'b0;
      modeStrobe <= 1'b0;
    end else begin
      cfgStrobe  <= 1'b0;
      modeStrobe <= 1'b0;
      if (ctl.clearShift)   shiftReg <= '0;
      else if (ctl.shiftEn) shiftReg <= {shiftReg[SHIFT_W-2:0], dinBit};
      if (ctl.byteDone) begin
        shiftReg <= '0;
        if (isModeByte) begin
          convMode   <= payload[PAYLOAD_W-1:CHAN_LSB];
          modeStrobe <= 1'b1;
        end else begin
          chanSel   <= payload[PAYLOAD_W-1:CHAN_LSB];
          diffSel   <= payload[DIFF_POS];
          rangeCode <= payload[RANGE_W-1:0];
          cfgStrobe <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/adc_cmd_decoder.sv
module adc_cmd_decoder
  import adc_cmd_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int CHAN_W       = 3,
  parameter int RANGE_W      = 3,
  parameter int MODE0_SAMPLE = 14,
  parameter int MODE1_SAMPLE = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               csN,
  input  logic               sclk,
  input  logic               din,
  output logic [CHAN_W-1:0]  chanSel,
  output logic               diffSel,
  output logic [RANGE_W-1:0] rangeCode,
  output logic [CHAN_W-1:0]  convMode,
  output logic               cfgStrobe,
  output logic               modeStrobe,
  output logic               samplePulse,
  output logic               strobeOut
);
  localparam int BYTE_BITS = CHAN_W + RANGE_W + 2;

  logic [2:0]  pinsSync;
  ctlStrobes_t ctl;
  logic        isModeByte;

  adc_pin_sync #(
    .WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b100)
  ) u_sync (
    .clk(clk), .rstN(rstN),
    .pinsIn({csN, sclk, din}),
    .pinsSync(pinsSync)
  );

  adc_cmd_ctrl #(
    .BYTE_BITS(BYTE_BITS), .MODE_W(CHAN_W),
    .MODE0_SAMPLE(MODE0_SAMPLE), .MODE1_SAMPLE(MODE1_SAMPLE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .csActive(~pinsSync[2]), .sclkLvl(pinsSync[1]), .dinBit(pinsSync[0]),
    .isModeByte(isModeByte), .convMode(convMode),
    .ctl(ctl), .samplePulse(samplePulse), .strobeOut(strobeOut)
  );

  adc_cmd_datapath #(
    .CHAN_W(CHAN_W), .RANGE_W(RANGE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dinBit(pinsSync[0]),
    .isModeByte(isModeByte), .chanSel(chanSel), .diffSel(diffSel),
    .rangeCode(rangeCode), .convMode(convMode),
    .cfgStrobe(cfgStrobe), .modeStrobe(modeStrobe)
  );
endmodule

// File: rtl/adc_cmd_decoder_chk.sv
module adc_cmd_decoder_chk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] chanSel,
  input logic       diffSel,
  input logic [2:0] rangeCode,
  input logic [2:0] convMode,
  input logic       cfgStrobe,
  input logic       modeStrobe,
  input logic       samplePulse,
  input logic       strobeOut
);
  AST_ONE_BYTE_KIND: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgStrobe && modeStrobe)); // R3

  AST_MODE_CHANGE_NEEDS_MODE_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(convMode) |-> modeStrobe); // R3

  AST_CFG_CHANGE_NEEDS_CFG_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({chanSel, diffSel, rangeCode}) |-> cfgStrobe); // R4

  AST_SAMPLE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    samplePulse |=> !samplePulse); // R5

  AST_NO_SAMPLE_OTHER_MODES: assert property (@(posedge clk) disable iff (!rstN)
    samplePulse |-> (convMode <= 3'd1)); // R7

  AST_STROBE_LOW_MODE0: assert property (@(posedge clk) disable iff (!rstN)
    (convMode == 3'd0) |-> !strobeOut); // R8

  AST_STROBE_RISES_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobeOut) |-> $past(samplePulse) == 1'b0 && samplePulse); // R8
endmodule

bind adc_cmd_decoder adc_cmd_decoder_chk u_chk (.*);

// File: tb/adc_cmd_decoder_tb.sv
module adc_cmd_decoder_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, csN, sclk, din;
  logic [2:0] chanSel, rangeCode, convMode;
  logic diffSel, cfgStrobe, modeStrobe, samplePulse, strobeOut;

  adc_cmd_decoder u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(din),
    .chanSel(chanSel), .diffSel(diffSel), .rangeCode(rangeCode),
    .convMode(convMode), .cfgStrobe(cfgStrobe), .modeStrobe(modeStrobe),
    .samplePulse(samplePulse), .strobeOut(strobeOut)
  );

  int testsRun = 0, testsFailed = 0;
  int pulseCnt = 0, cfgCnt = 0, modeCnt = 0, pulseFall = 0, frameFall = 0;

  always @(posedge clk) begin
    if (rstN) begin
      if (samplePulse) begin pulseCnt++; pulseFall = frameFall; end
      if (cfgStrobe)  cfgCnt++;
      if (modeStrobe) modeCnt++;
    end
  end

  // lead[4] byte[8] clocks[5] chan[3] dif[1] range[3] mode[3] pulseEdge[5]
  localparam int NVEC = 7;
  localparam logic [31:0] VECS [NVEC] = '{
    {4'd0, 8'hD3, 5'd16, 3'd5, 1'b0, 3'd3, 3'd0, 5'd14},
    {4'd0, 8'h98, 5'd8,  3'd5, 1'b0, 3'd3, 3'd1, 5'd0},
    {4'd3, 8'hAE, 5'd16, 3'd2, 1'b1, 3'd6, 3'd1, 5'd16},
    {4'd1, 8'hF8, 5'd8,  3'd2, 1'b1, 3'd6, 3'd7, 5'd0},
    {4'd0, 8'h81, 5'd16, 3'd0, 1'b0, 3'd1, 3'd7, 5'd0},
    {4'd5, 8'h88, 5'd8,  3'd0, 1'b0, 3'd1, 3'd0, 5'd0},
    {4'd2, 8'hFF, 5'd16, 3'd7, 1'b1, 3'd7, 3'd0, 5'd14}
  };

  task automatic check(input string tag, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic sclkCycle(input logic b);
    din = b;
    repeat (8) @(negedge clk);
    sclk = 1'b1;
    repeat (8) @(negedge clk);
    sclk = 1'b0;
    frameFall++;
  endtask

  task automatic csLow();
    @(negedge clk);
    csN = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic csHigh();
    repeat (8) @(negedge clk);
    csN = 1'b1;
    din = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic runFrame(input int lead, input logic [7:0] b, input int nClk, input logic tailBit);
    pulseCnt = 0; cfgCnt = 0; modeCnt = 0; pulseFall = 0;
    csLow();
    for (int i = 0; i < lead; i++) sclkCycle(1'b0);
    frameFall = 0;
    for (int i = 7; i >= 0; i--) sclkCycle(b[i]);
    for (int i = 8; i < nClk; i++) sclkCycle(tailBit);
    din = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic checkRegs(input string tag, input int ch, input int dif, input int rg, input int md);
    check({tag, " chanSel"},   chanSel,   ch);
    check({tag, " diffSel"},   diffSel,   dif);
    check({tag, " rangeCode"}, rangeCode, rg);
    check({tag, " convMode"},  convMode,  md);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    testsRun++; testsFailed++;
    $display("FAIL watchdog R1..: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    rstN = 1'b0; csN = 1'b1; sclk = 1'b0; din = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    checkRegs("R1 reset", 0, 0, 0, 0);
    check("R1 strobes", {cfgStrobe, modeStrobe, samplePulse, strobeOut}, 0);

    // Table walk: R2 leading zeros, R3/R4 classification, R5/R6/R7 sample edge, R8 strobe
    for (int v = 0; v < NVEC; v++) begin
      logic [31:0] e;
      logic isMode;
      e = VECS[v];
      isMode = (e[23:20] == 4'b1000);
      runFrame(int'(e[31:28]), e[27:20], int'(e[19:15]), 1'b0);
      checkRegs($sformatf("R2 R3 R4 vec%0d", v), e[14:12], e[11], e[10:8], e[7:5]);
      check($sformatf("R3 vec%0d modeStrobe count", v), modeCnt, isMode ? 1 : 0);
      check($sformatf("R4 vec%0d cfgStrobe count", v), cfgCnt, isMode ? 0 : 1);
      check($sformatf("R5 R6 R7 vec%0d pulse count", v), pulseCnt, (e[4:0] != 0) ? 1 : 0);
      if (e[4:0] != 0)
        check($sformatf("R5 R6 vec%0d pulse edge", v), pulseFall, int'(e[4:0]));
      check($sformatf("R8 vec%0d strobe before cs", v), strobeOut,
            (e[7:5] == 3'd1 && e[4:0] != 0) ? 1 : 0);
      csHigh();
      check($sformatf("R8 vec%0d strobe after cs", v), strobeOut, 0);
    end

    // R9 partial byte discarded (mode 0, cfg 7/1/7 held)
    pulseCnt = 0; cfgCnt = 0; modeCnt = 0;
    csLow();
    sclkCycle(1'b1); sclkCycle(1'b0); sclkCycle(1'b1); sclkCycle(1'b1);
    csHigh();
    checkRegs("R9 partial", 7, 1, 7, 0);
    check("R9 partial strobes", cfgCnt + modeCnt, 0);

    // R9 abort inside conversion window: byte taken, no pulse
    runFrame(0, 8'hC2, 12, 1'b0);
    csHigh();
    checkRegs("R9 abort conv regs", 4, 0, 2, 0);
    check("R9 abort conv pulse", pulseCnt, 0);
    // R9 next frame counts from its own start bit
    runFrame(1, 8'hA4, 16, 1'b0);
    check("R9 fresh frame pulse count", pulseCnt, 1);
    check("R9 fresh frame pulse edge", pulseFall, 14);
    csHigh();

    // R10 DIN held high during conversion window is not framed
    runFrame(0, 8'hB5, 16, 1'b1);
    checkRegs("R10 tail ones", 3, 0, 5, 0);
    check("R10 cfg count", cfgCnt, 1);
    check("R10 mode count", modeCnt, 0);
    check("R10 pulse edge", pulseFall, 14);
    check("R8 mode0 strobe low", strobeOut, 0);
    csHigh();
    check("R9 trailing start discarded", cfgCnt + modeCnt, 1);

    // R8 strobe cleared by mode-control byte in same select window
    runFrame(0, 8'h98, 8, 1'b0);
    csHigh();
    runFrame(0, 8'hAE, 16, 1'b0);
    check("R6 mode1 pulse edge", pulseFall, 16);
    check("R8 mode1 strobe high", strobeOut, 1);
    runFrame(0, 8'h88, 8, 1'b0);
    check("R8 strobe cleared by mode byte", strobeOut, 0);
    check("R3 mode back to 0", convMode, 0);
    csHigh();

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule